// File: doc/BRIEF.md
# I2C Bus-Clear Pulse Generator

This block frees an I2C bus when a stuck target device holds SDA low. When a clear request is accepted, it releases SDA and pulls SCL low and then releases it a programmed number of times. The stuck device can then clock out whatever bit it was holding. Each pulse has a fixed low time and a fixed high time, counted in system clocks. The pulse count comes from a 4-bit field that the block samples when it accepts the request. A busy flag stays high while the pulse train runs. A one-cycle done pulse marks the end of every request, including one that emits no pulses.

The block also samples the SCL and SDA pads through synchronisers and presents them on a 2-bit monitor port, with SDA in bit 0 and SCL in bit 1. Software can therefore request one pulse, read the SDA level and repeat until the bus is free (both bits high). A clear request made while SDA already reads high finishes at once. The synchronised SDA also feeds a glitch filter that drops short spikes. A configuration input bypasses this filter, because the filter delays repeated-start conditions. The retry policy that decides how often to ask for recovery lives outside this block.

Top module: `busclr_gen`

## Requirements
- R1: After synchronous reset, scl_oe, sda_oe, busy and done are all 0, and mon reads 2'b11 until the first sampled line levels have passed through the synchroniser.
- R2: A request accepted with count N (1..15) while the synchronised SDA is low produces exactly N SCL pulses. In each pulse, scl_oe is 1 (SCL driven low) for LOW_CYC cycles and then 0 (SCL released) for HIGH_CYC cycles. The first low phase starts in the cycle after the request edge.
- R3: sda_oe is 0 at all times; SDA is never driven.
- R4: busy is 1 for exactly N*(LOW_CYC+HIGH_CYC) cycles, starting the cycle after an accepted pulse request. done is 1 for a single cycle, in the cycle where busy returns to 0.
- R5: A request made while mon bit 0 (SDA) is 1, or with count 0, emits no pulses. busy stays 0 and done is 1 in the next cycle.
- R6: A request made while busy is 1 is ignored, including one in the last busy cycle. The running train keeps its length and no new train follows it.
- R7: The block reads cyc_cnt only in the cycle it accepts a request. Changing cyc_cnt, or SDA rising during the train, does not change the number of pulses.
- R8: mon bit 0 carries the SDA level and bit 1 the SCL level, each delayed by SYNC_STAGES clock edges.
- R9: With filt_bypass at 0, an SDA level change lasting fewer than FILT_LEN cycles never reaches sda_flt. A level held for FILT_LEN cycles or longer does reach it.
- R10: With filt_bypass at 1, sda_flt equals mon bit 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Bus-clear request strobe |
| cyc_cnt | input | 4 | Number of SCL pulses to emit, 0..15 |
| filt_bypass | input | 1 | 1 = sda_flt follows synchronised SDA with no filtering |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_oe | output | 1 | 1 = drive SCL low (open drain) |
| sda_oe | output | 1 | 1 = drive SDA low; always 0 |
| busy | output | 1 | Pulse train in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| mon | output | 2 | Live line levels: bit 0 SDA, bit 1 SCL |
| sda_flt | output | 1 | Glitch-filtered (or bypassed) SDA for the controller |

## Verification
Two events can fall in the same cycle here. One is a new request arriving in the last busy cycle of a train. The other is the stuck device releasing SDA while a train is still running. The bench drives a request strobe with a different count exactly on the final high-phase cycle, and another one early in the train. It then checks that the measured pulse count, low widths and busy length match the count accepted first, and that busy stays low afterwards. A directed train also raises SDA halfway through. The expected outcome is the full programmed pulse count, because the SDA check applies only when a request is accepted.

// File: rtl/busclr_pkg.sv
package busclr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Bit order matters: mon[1] = SCL, mon[0] = SDA.
    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/busclr_sync.sv
module busclr_sync
    import busclr_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  lines_t d,
    output lines_t q
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= d.scl;
                    sda_sh <= d.sda;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], d.scl};
                    sda_sh <= {sda_sh[STAGES-2:0], d.sda};
                end
            end
        end
    endgenerate

    assign q.scl = scl_sh[STAGES-1];
    assign q.sda = sda_sh[STAGES-1];
endmodule

// File: rtl/busclr_filt.sv
module busclr_filt
    import busclr_pkg::*;
#(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic bypass,
    output logic dout
);
    localparam int unsigned CW = bits_for(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic          held;
    logic [CW-1:0] run;

    // The held level changes only after LEN consecutive differing samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b1;
            run  <= '0;
        end else if (din == held) begin
            run <= '0;
        end else if (run == LAST) begin
            held <= din;
            run  <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    assign dout = bypass ? din : held;
endmodule

// File: rtl/busclr_seq.sv
module busclr_seq
    import busclr_pkg::*;
#(
    parameter int unsigned LOW_CYC  = 588,
    parameter int unsigned HIGH_CYC = 500,
    parameter int unsigned CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [CNT_W-1:0] cnt,
    input  logic             sda_hi,
    output logic             scl_oe,
    output logic             busy,
    output logic             done
);
    localparam int unsigned TW = bits_for(max2(LOW_CYC, HIGH_CYC));
    localparam logic [TW-1:0] LOW_LAST  = TW'(LOW_CYC - 1);
    localparam logic [TW-1:0] HIGH_LAST = TW'(HIGH_CYC - 1);

    phase_e           phase;
    logic [TW-1:0]    tmr;
    logic [CNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            tmr   <= '0;
            left  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req) begin
                        if (cnt == '0 || sda_hi) begin
                            done <= 1'b1;
                        end else begin
                            phase <= PH_LOW;
                            tmr   <= LOW_LAST;
                            left  <= cnt;
                        end
                    end
                end
                PH_LOW: begin
                    if (tmr == '0) begin
                        phase <= PH_HIGH;
                        tmr   <= HIGH_LAST;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else if (left == CNT_W'(1)) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        left  <= left - 1'b1;
                        phase <= PH_LOW;
                        tmr   <= LOW_LAST;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign scl_oe = (phase == PH_LOW);
    assign busy   = (phase != PH_IDLE);
endmodule

// File: rtl/busclr_gen.sv
module busclr_gen
    import busclr_pkg::*;
#(
    parameter int unsigned LOW_CYC     = 588,
    parameter int unsigned HIGH_CYC    = 500,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic [3:0] cyc_cnt,
    input  logic       filt_bypass,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       done,
    output logic [1:0] mon,
    output logic       sda_flt
);
    lines_t pads;
    lines_t synced;

    assign pads.scl = scl_i;
    assign pads.sda = sda_i;

    busclr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pads),
        .q   (synced)
    );

    busclr_filt #(.LEN(FILT_LEN)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .din    (synced.sda),
        .bypass (filt_bypass),
        .dout   (sda_flt)
    );

    busclr_seq #(
        .LOW_CYC  (LOW_CYC),
        .HIGH_CYC (HIGH_CYC),
        .CNT_W    (4)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .cnt    (cyc_cnt),
        .sda_hi (synced.sda),
        .scl_oe (scl_oe),
        .busy   (busy),
        .done   (done)
    );

    assign mon    = synced;
    assign sda_oe = 1'b0;
endmodule

// File: rtl/busclr_chk.sv
module busclr_chk (
    input logic       clk,
    input logic       rst,
    input logic       req,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       busy,
    input logic       done,
    input logic [1:0] mon
);
    // R3
    sda_released_chk: assert property (@(posedge clk) disable iff (rst) !sda_oe);

    // R2
    scl_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst) scl_oe |-> busy);

    // R4
    done_at_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);

    // R4
    busy_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req) |=> !busy);

    // R5
    free_bus_quick_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !busy && mon[0]) |=> (done && !busy));
endmodule

bind busclr_gen busclr_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .busy   (busy),
    .done   (done),
    .mon    (mon)
);

// File: tb/sim_busclr_gen.sv
`timescale 1ns/1ps
module sim_busclr_gen;
    localparam int LO = 6;
    localparam int HI = 4;
    localparam int FL = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [3:0] cyc_cnt = '0;
    logic       filt_bypass = 1'b0;
    logic       scl_rel = 1'b1;
    logic       sda_i = 1'b1;
    logic       scl_oe, sda_oe, busy, done, sda_flt;
    logic [1:0] mon;
    logic       scl_i;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    assign scl_i = scl_oe ? 1'b0 : scl_rel;

    busclr_gen #(
        .LOW_CYC(LO), .HIGH_CYC(HI), .SYNC_STAGES(2), .FILT_LEN(FL)
    ) u0 (
        .clk(clk), .rst(rst), .req(req), .cyc_cnt(cyc_cnt),
        .filt_bypass(filt_bypass), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
        .mon(mon), .sda_flt(sda_flt)
    );

    function automatic int exp_busy(input int n);
        return n * (LO + HI);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Runs one train with count n; optionally injects a request mid-train,
    // on the last busy cycle, and SDA rising at cycle sda_up (-1 = never).
    task automatic train(input int n, input int sda_up);
        int rises = 0, lows = 0, bcyc = 0, run = 0, badw = 0, sdo = 0;
        bit prev = 1'b0;
        bit seen_done = 1'b0;
        sda_i = 1'b0;
        repeat (4) @(negedge clk);
        cyc_cnt = 4'(n);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (sda_oe) sdo++;
            if (done) begin
                seen_done = 1'b1;
                chk(!busy, "R4 busy low with done", busy, 0);
                break;
            end
            if (busy) bcyc++;
            if (scl_oe && !prev) rises++;
            if (scl_oe) begin lows++; run++; end
            if (!scl_oe && prev) begin
                if (run != LO) badw++;
                run = 0;
            end
            prev = scl_oe;
            req = 1'b0;
            cyc_cnt = 4'(n);
            if (i == 2 || i == exp_busy(n) - 1) begin
                req = 1'b1;
                cyc_cnt = 4'd15;
            end
            if (i == sda_up) sda_i = 1'b1;
            @(negedge clk);
        end
        req = 1'b0;
        chk(seen_done, "R4 done seen", seen_done, 1);
        chk(rises == n, "R2 pulse count", rises, n);
        chk(lows == n * LO && badw == 0, "R2 low widths", lows, n * LO);
        chk(bcyc == exp_busy(n), "R4 busy length", bcyc, exp_busy(n));
        chk(sdo == 0, "R3 sda never driven", sdo, 0);
        @(negedge clk);
        chk(!done && !busy, "R6 no follow-on train", busy, 0);
        sda_i = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int nrand;
        void'($urandom(32'd11));
        repeat (3) @(negedge clk);
        // R1
        chk(!scl_oe && !sda_oe && !busy && !done && mon == 2'b11, "R1 reset state",
            {scl_oe, sda_oe, busy, done}, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R8: monitor bits and sync latency
        scl_rel = 1'b0;
        sda_i = 1'b1;
        @(negedge clk);
        chk(mon == 2'b11, "R8 mon before latency", mon, 3);
        @(negedge clk);
        chk(mon == 2'b01, "R8 scl low sda high", mon, 1);
        scl_rel = 1'b1;
        sda_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(mon == 2'b10, "R8 scl high sda low", mon, 2);
        sda_i = 1'b1;
        repeat (FL + 4) @(negedge clk);

        // R5: SDA already high, and count zero
        cyc_cnt = 4'd5;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(done && !busy && !scl_oe, "R5 free bus completes at once", done, 1);
        @(negedge clk);
        chk(!done && !busy, "R5 single done", done, 0);
        sda_i = 1'b0;
        repeat (3) @(negedge clk);
        cyc_cnt = 4'd0;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(done && !busy, "R5 zero count completes", done, 1);
        sda_i = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R4 R6 R7: directed corners then random counts
        train(1, -1);
        train(15, -1);
        train(4, 12);  // R7 SDA rises mid-train
        for (int k = 0; k < 5; k++) begin
            nrand = 1 + int'($urandom_range(14));
            train(nrand, -1);
        end

        // R9: filter rejects short glitch, passes long level
        filt_bypass = 1'b0;
        repeat (4) @(negedge clk);
        begin
            int leak = 0;
            sda_i = 1'b0;
            repeat (FL - 1) @(negedge clk);
            sda_i = 1'b1;
            for (int i = 0; i < FL + 6; i++) begin
                if (!sda_flt) leak++;
                @(negedge clk);
            end
            chk(leak == 0, "R9 glitch rejected", leak, 0);
        end
        sda_i = 1'b0;
        repeat (2 + FL + 1) @(negedge clk);
        chk(sda_flt == 1'b0, "R9 long low passes", sda_flt, 0);
        sda_i = 1'b1;
        repeat (2 + FL + 1) @(negedge clk);
        chk(sda_flt == 1'b1, "R9 long high passes", sda_flt, 1);

        // R10: bypass follows synchronised SDA every cycle
        filt_bypass = 1'b1;
        begin
            int diff = 0;
            for (int i = 0; i < 40; i++) begin
                sda_i = 1'($urandom_range(1));
                @(negedge clk);
                if (sda_flt != mon[0]) diff++;
            end
            chk(diff == 0, "R10 bypass tracks mon", diff, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule